// File: doc/BRIEF.md
# Window spill/fill trap generator

This block keeps the register-window bookkeeping of a 64-bit windowed-register processor. It holds five counters: windows free to save into (save credit), windows holding data to restore (restore credit), windows known to be clean, windows that belong to another address space (foreign count), and a 6-bit trap-state selector. It also holds the current window pointer. Each cycle the pipeline can present one window operation: SAVE, RESTORE, FLUSH, SAVED or RESTORED. The block either commits the operation to the counters and the window pointer, or it raises a trap and reports a 9-bit trap type. The trap type tells the trap logic whether to spill, fill or clean a window, and which handler slot to use.

The window pointer is stored in the order the register file uses. The read port shows it reversed: `NWIN-1` minus the stored value. A write to the pointer is reduced modulo `NWIN` and then stored reversed. A small controller has two states. In RUN it accepts operations. In TRAP it presents the pending trap for exactly one cycle. It moves RUN→TRAP when an accepted operation traps, and TRAP→RUN unconditionally on the next cycle. An operation that does not trap leaves the controller in RUN.

Top module: `win_trap_gen`

## Requirements
- R1: An accepted SAVE with save credit 0 raises a spill trap. It changes no counter and does not move the window pointer.
- R2: An accepted SAVE with nonzero save credit, where the clean count equals the restore credit, raises trap type 0x024. It changes no counter.
- R3: An accepted RESTORE with restore credit 0 raises a fill trap. It changes no counter.
- R4: Spill and fill types are built from a base (spill 0x080, fill 0x0C0). If the foreign count is nonzero, the base is ORed with 0x020 and with selector bits [5:3] placed at type bits [4:2]. Otherwise the base is ORed with selector bits [2:0] placed at [4:2]. `trap_type` reads 0 whenever `trap_valid` is low.
- R5: A SAVE that does not trap lowers the save credit by 1 and raises the restore credit by 1. A RESTORE that does not trap does the opposite. SAVE raises the read window pointer by 1 modulo `NWIN`, and RESTORE lowers it by 1.
- R6: FLUSH raises a spill trap whenever the save credit differs from `NWIN-2`. Otherwise it has no effect.
- R7: SAVED raises the save credit by 1. It then lowers the foreign count if that count is nonzero, and lowers the restore credit otherwise.
- R8: RESTORED raises the restore credit by 1. It raises the clean count only while that count is below `NWIN-1`. It then lowers the foreign count if that count is nonzero, and lowers the save credit otherwise.
- R9: A pointer write (select 5) stores `NWIN-1-(data mod NWIN)`. The read port returns `NWIN-1` minus the stored pointer, so it shows `data mod NWIN`.
- R10: `trap_valid` is high for exactly one cycle, the cycle after the trapping operation. An operation presented during that cycle is ignored. An operation presented together with `wr_en` is ignored, and the write is applied.
- R11: After reset: save credit `NWIN-2`, restore credit 0, clean count `NWIN-1`, foreign count 0, selector 0, read pointer `NWIN-1`, no trap.
- R12: The write select chooses the target: 0 save credit, 1 restore credit, 2 clean count, 3 foreign count, 4 selector, 5 pointer. Counter writes keep the low `CW` bits of the data, and selector writes keep the low 6 bits.

Operation encoding on `op_code`: 1 SAVE, 2 RESTORE, 3 FLUSH, 4 SAVED, 5 RESTORED. Any other value does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | A window operation is presented |
| op_code | input | 3 | Operation code (see encoding) |
| wr_en | input | 1 | Write strobe for the counters or the pointer |
| wr_sel | input | 3 | Write target select |
| wr_data | input | 8 | Write data |
| trap_valid | output | 1 | Trap pending this cycle |
| trap_type | output | 9 | Trap type code, 0 when no trap |
| cwp_o | output | CW | Window pointer, read (reversed) view |
| cansave_o | output | CW | Save credit |
| canrestore_o | output | CW | Restore credit |
| cleanwin_o | output | CW | Clean-window count |
| otherwin_o | output | CW | Foreign window count |
| wstate_o | output | 6 | Trap-state selector |

## Verification
Every result is registered once. Counter and pointer updates, and a raised trap, all appear in the cycle after the edge that takes the operation or write. The trap stays visible for that one cycle only. The bench drives inputs on the falling edge. It holds each strobe through a single rising edge and samples at the next falling edge, which is exactly the cycle in which the result is due. It adds an idle cycle after every operation, so that the next stimulus never lands in the TRAP cycle by accident. The only exception is the directed test that lands an operation in the TRAP cycle on purpose.

// File: rtl/wtg_pkg.sv
package wtg_pkg;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_SAVE     = 3'd1,
        OP_RESTORE  = 3'd2,
        OP_FLUSH    = 3'd3,
        OP_SAVED    = 3'd4,
        OP_RESTORED = 3'd5
    } win_op_e;

    typedef enum logic [2:0] {
        SEL_CANSAVE    = 3'd0,
        SEL_CANRESTORE = 3'd1,
        SEL_CLEANWIN   = 3'd2,
        SEL_OTHERWIN   = 3'd3,
        SEL_WSTATE     = 3'd4,
        SEL_CWP        = 3'd5
    } win_sel_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_TRAP = 1'b1
    } ctrl_state_e;

    typedef enum logic [1:0] {
        TK_SPILL = 2'd0,
        TK_FILL  = 2'd1,
        TK_CLEAN = 2'd2
    } trap_kind_e;

    localparam logic [8:0] TT_SPILL_BASE = 9'h080;
    localparam logic [8:0] TT_FILL_BASE  = 9'h0C0;
    localparam logic [8:0] TT_FOREIGN    = 9'h020;
    localparam logic [8:0] TT_CLEAN      = 9'h024;

endpackage

// File: rtl/wtg_type_enc.sv
module wtg_type_enc
    import wtg_pkg::*;
(
    input  trap_kind_e  kind,
    input  logic        foreign_nz,
    input  logic [5:0]  selector,
    output logic [8:0]  ttype
);

    logic [2:0] slot;
    logic [8:0] slot_bits;
    logic [8:0] foreign_bit;

    always_comb begin
        slot        = foreign_nz ? selector[5:3] : selector[2:0];
        slot_bits   = {4'b0000, slot, 2'b00};
        foreign_bit = foreign_nz ? TT_FOREIGN : 9'h000;
        unique case (kind)
            TK_SPILL: ttype = TT_SPILL_BASE | foreign_bit | slot_bits;
            TK_FILL:  ttype = TT_FILL_BASE | foreign_bit | slot_bits;
            TK_CLEAN: ttype = TT_CLEAN;
            default:  ttype = 9'h000;
        endcase
    end

endmodule

// File: rtl/wtg_regs.sv
module wtg_regs
    import wtg_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CW = $clog2(NWIN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_save,
    input  logic          cmd_restore,
    input  logic          cmd_saved,
    input  logic          cmd_restored,
    input  logic          wr_en,
    input  win_sel_e      wr_sel,
    input  logic [7:0]    wr_data,
    output logic [CW-1:0] cansave,
    output logic [CW-1:0] canrestore,
    output logic [CW-1:0] cleanwin,
    output logic [CW-1:0] otherwin,
    output logic [5:0]    wstate,
    output logic [CW-1:0] cwp_int
);

    localparam logic [CW-1:0] LAST_W  = CW'(NWIN - 1);
    localparam logic [CW-1:0] RST_CS  = CW'(NWIN - 2);
    localparam logic [CW-1:0] ONE_W   = CW'(1);
    localparam logic [7:0]    NWIN_B  = 8'(NWIN);

    logic [CW-1:0] cs_n, cr_n, cw_n, ow_n, cwp_n;
    logic [5:0]    ws_n;
    logic [7:0]    wr_mod;

    assign wr_mod = wr_data % NWIN_B;

    always_comb begin
        cs_n  = cansave;
        cr_n  = canrestore;
        cw_n  = cleanwin;
        ow_n  = otherwin;
        ws_n  = wstate;
        cwp_n = cwp_int;
        if (wr_en) begin
            unique case (wr_sel)
                SEL_CANSAVE:    cs_n  = wr_data[CW-1:0];
                SEL_CANRESTORE: cr_n  = wr_data[CW-1:0];
                SEL_CLEANWIN:   cw_n  = wr_data[CW-1:0];
                SEL_OTHERWIN:   ow_n  = wr_data[CW-1:0];
                SEL_WSTATE:     ws_n  = wr_data[5:0];
                SEL_CWP:        cwp_n = LAST_W - wr_mod[CW-1:0];
                default:        ;
            endcase
        end else begin
            if (cmd_save) begin
                cs_n  = cansave - ONE_W;
                cr_n  = canrestore + ONE_W;
                cwp_n = (cwp_int == '0) ? LAST_W : cwp_int - ONE_W;
            end
            if (cmd_restore) begin
                cs_n  = cansave + ONE_W;
                cr_n  = canrestore - ONE_W;
                cwp_n = (cwp_int == LAST_W) ? '0 : cwp_int + ONE_W;
            end
            if (cmd_saved) begin
                cs_n = cansave + ONE_W;
                if (otherwin == '0) begin
                    cr_n = canrestore - ONE_W;
                end else begin
                    ow_n = otherwin - ONE_W;
                end
            end
            if (cmd_restored) begin
                cr_n = canrestore + ONE_W;
                if (cleanwin < LAST_W) begin
                    cw_n = cleanwin + ONE_W;
                end
                if (otherwin == '0) begin
                    cs_n = cansave - ONE_W;
                end else begin
                    ow_n = otherwin - ONE_W;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cansave    <= RST_CS;
            canrestore <= '0;
            cleanwin   <= LAST_W;
            otherwin   <= '0;
            wstate     <= '0;
            cwp_int    <= '0;
        end else begin
            cansave    <= cs_n;
            canrestore <= cr_n;
            cleanwin   <= cw_n;
            otherwin   <= ow_n;
            wstate     <= ws_n;
            cwp_int    <= cwp_n;
        end
    end

endmodule

// File: rtl/wtg_ctrl.sv
module wtg_ctrl
    import wtg_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CW = $clog2(NWIN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  win_op_e       op_code,
    input  logic          wr_en,
    input  logic [CW-1:0] cansave,
    input  logic [CW-1:0] canrestore,
    input  logic [CW-1:0] cleanwin,
    input  logic [8:0]    enc_type,
    output trap_kind_e    kind,
    output logic          cmd_save,
    output logic          cmd_restore,
    output logic          cmd_saved,
    output logic          cmd_restored,
    output logic          trap_valid,
    output logic [8:0]    trap_type
);

    localparam logic [CW-1:0] FLUSH_OK = CW'(NWIN - 2);

    ctrl_state_e state, state_n;
    logic        accept;
    logic        raise;
    logic [8:0]  tt_q;

    assign accept = op_valid && !wr_en && (state == ST_RUN);

    // decision and next state
    always_comb begin
        raise        = 1'b0;
        kind         = TK_SPILL;
        cmd_save     = 1'b0;
        cmd_restore  = 1'b0;
        cmd_saved    = 1'b0;
        cmd_restored = 1'b0;
        if (accept) begin
            unique case (op_code)
                OP_SAVE: begin
                    if (cansave == '0) begin
                        raise = 1'b1;
                        kind  = TK_SPILL;
                    end else if (cleanwin == canrestore) begin
                        raise = 1'b1;
                        kind  = TK_CLEAN;
                    end else begin
                        cmd_save = 1'b1;
                    end
                end
                OP_RESTORE: begin
                    if (canrestore == '0) begin
                        raise = 1'b1;
                        kind  = TK_FILL;
                    end else begin
                        cmd_restore = 1'b1;
                    end
                end
                OP_FLUSH: begin
                    if (cansave != FLUSH_OK) begin
                        raise = 1'b1;
                        kind  = TK_SPILL;
                    end
                end
                OP_SAVED:    cmd_saved    = 1'b1;
                OP_RESTORED: cmd_restored = 1'b1;
                default:     ;
            endcase
        end
        unique case (state)
            ST_RUN:  state_n = raise ? ST_TRAP : ST_RUN;
            ST_TRAP: state_n = ST_RUN;
            default: state_n = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
            tt_q  <= '0;
        end else begin
            state <= state_n;
            if (raise) begin
                tt_q <= enc_type;
            end
        end
    end

    // outputs
    always_comb begin
        trap_valid = 1'b0;
        trap_type  = '0;
        unique case (state)
            ST_TRAP: begin
                trap_valid = 1'b1;
                trap_type  = tt_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/win_trap_gen.sv
module win_trap_gen
    import wtg_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CW = $clog2(NWIN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [2:0]    op_code,
    input  logic          wr_en,
    input  logic [2:0]    wr_sel,
    input  logic [7:0]    wr_data,
    output logic          trap_valid,
    output logic [8:0]    trap_type,
    output logic [CW-1:0] cwp_o,
    output logic [CW-1:0] cansave_o,
    output logic [CW-1:0] canrestore_o,
    output logic [CW-1:0] cleanwin_o,
    output logic [CW-1:0] otherwin_o,
    output logic [5:0]    wstate_o
);

    localparam logic [CW-1:0] LAST_W = CW'(NWIN - 1);

    trap_kind_e    kind;
    logic          cmd_save, cmd_restore, cmd_saved, cmd_restored;
    logic [8:0]    enc_type;
    logic [CW-1:0] cwp_int;

    wtg_ctrl #(.NWIN(NWIN)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_valid     (op_valid),
        .op_code      (win_op_e'(op_code)),
        .wr_en        (wr_en),
        .cansave      (cansave_o),
        .canrestore   (canrestore_o),
        .cleanwin     (cleanwin_o),
        .enc_type     (enc_type),
        .kind         (kind),
        .cmd_save     (cmd_save),
        .cmd_restore  (cmd_restore),
        .cmd_saved    (cmd_saved),
        .cmd_restored (cmd_restored),
        .trap_valid   (trap_valid),
        .trap_type    (trap_type)
    );

    wtg_type_enc u_enc (
        .kind       (kind),
        .foreign_nz (otherwin_o != '0),
        .selector   (wstate_o),
        .ttype      (enc_type)
    );

    wtg_regs #(.NWIN(NWIN)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_save     (cmd_save),
        .cmd_restore  (cmd_restore),
        .cmd_saved    (cmd_saved),
        .cmd_restored (cmd_restored),
        .wr_en        (wr_en),
        .wr_sel       (win_sel_e'(wr_sel)),
        .wr_data      (wr_data),
        .cansave      (cansave_o),
        .canrestore   (canrestore_o),
        .cleanwin     (cleanwin_o),
        .otherwin     (otherwin_o),
        .wstate       (wstate_o),
        .cwp_int      (cwp_int)
    );

    // reversed read view; a power-of-two window count needs only inversion
    generate
        if ((NWIN & (NWIN - 1)) == 0) begin : g_rev_pow2
            assign cwp_o = ~cwp_int;
        end else begin : g_rev_sub
            assign cwp_o = LAST_W - cwp_int;
        end
    endgenerate

endmodule

// File: rtl/wtg_chk.sv
module wtg_chk #(
    parameter int NWIN = 8,
    localparam int CW = $clog2(NWIN)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic [2:0]    op_code,
    input logic          wr_en,
    input logic          trap_valid,
    input logic [8:0]    trap_type,
    input logic [CW-1:0] cwp_o,
    input logic [CW-1:0] cansave_o,
    input logic [CW-1:0] canrestore_o,
    input logic [CW-1:0] cleanwin_o
);

    logic go;
    assign go = op_valid && !wr_en && !trap_valid;

    AST_SPILL_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op_code == 3'd1 && cansave_o == '0) |=> (trap_valid && trap_type[8:6] == 3'b010)); // R1

    AST_CLEAN_ON_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op_code == 3'd1 && cansave_o != '0 && cleanwin_o == canrestore_o)
        |=> (trap_valid && trap_type == 9'h024)); // R2

    AST_FILL_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op_code == 3'd2 && canrestore_o == '0) |=> (trap_valid && trap_type[8:6] == 3'b011)); // R3

    AST_QUIET_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid |-> (trap_type == 9'h000)); // R4

    AST_CLEAN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op_code == 3'd5 && cleanwin_o == CW'(NWIN - 1)) |=> (cleanwin_o == CW'(NWIN - 1))); // R8

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cwp_o <= CW'(NWIN - 1))); // R9

    AST_TRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> !trap_valid); // R10

    AST_TRAP_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trap_valid) |-> $stable(cwp_o)); // R10

endmodule

bind win_trap_gen wtg_chk #(.NWIN(NWIN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid     (op_valid),
    .op_code      (op_code),
    .wr_en        (wr_en),
    .trap_valid   (trap_valid),
    .trap_type    (trap_type),
    .cwp_o        (cwp_o),
    .cansave_o    (cansave_o),
    .canrestore_o (canrestore_o),
    .cleanwin_o   (cleanwin_o)
);

// File: tb/tb_win_trap_gen.sv
`timescale 1ns/1ps
module tb_win_trap_gen;

    localparam int NWIN = 8;
    localparam int CW = $clog2(NWIN);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [2:0]    op_code = 3'd0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_sel = 3'd0;
    logic [7:0]    wr_data = 8'd0;
    logic          trap_valid;
    logic [8:0]    trap_type;
    logic [CW-1:0] cwp_o, cansave_o, canrestore_o, cleanwin_o, otherwin_o;
    logic [5:0]    wstate_o;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    win_trap_gen #(.NWIN(NWIN)) dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .trap_valid(trap_valid), .trap_type(trap_type), .cwp_o(cwp_o),
        .cansave_o(cansave_o), .canrestore_o(canrestore_o),
        .cleanwin_o(cleanwin_o), .otherwin_o(otherwin_o), .wstate_o(wstate_o)
    );

    typedef struct packed {
        logic [7:0] rq;
        logic [7:0] cs, cr, cw, ow, ws;
        logic [2:0] op;
        logic       trap;
        logic [8:0] tt;
        logic [7:0] ecs, ecr, ecw, eow;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{8'd1,  8'd0, 8'd3, 8'd7, 8'd0, 8'h2B, 3'd1, 1'b1, 9'h08C, 8'd0, 8'd3, 8'd7, 8'd0}, // R1 spill
        '{8'd4,  8'd0, 8'd3, 8'd7, 8'd2, 8'h2B, 3'd1, 1'b1, 9'h0B4, 8'd0, 8'd3, 8'd7, 8'd2}, // R4 foreign spill
        '{8'd2,  8'd3, 8'd2, 8'd2, 8'd0, 8'h00, 3'd1, 1'b1, 9'h024, 8'd3, 8'd2, 8'd2, 8'd0}, // R2 clean
        '{8'd5,  8'd3, 8'd2, 8'd5, 8'd0, 8'h00, 3'd1, 1'b0, 9'h000, 8'd2, 8'd3, 8'd5, 8'd0}, // R5 save
        '{8'd3,  8'd4, 8'd0, 8'd7, 8'd0, 8'h16, 3'd2, 1'b1, 9'h0D8, 8'd4, 8'd0, 8'd7, 8'd0}, // R3 fill
        '{8'd4,  8'd4, 8'd0, 8'd7, 8'd1, 8'h16, 3'd2, 1'b1, 9'h0E8, 8'd4, 8'd0, 8'd7, 8'd1}, // R4 foreign fill
        '{8'd5,  8'd2, 8'd3, 8'd5, 8'd0, 8'h00, 3'd2, 1'b0, 9'h000, 8'd3, 8'd2, 8'd5, 8'd0}, // R5 restore
        '{8'd6,  8'd6, 8'd0, 8'd7, 8'd0, 8'h00, 3'd3, 1'b0, 9'h000, 8'd6, 8'd0, 8'd7, 8'd0}, // R6 flush ok
        '{8'd6,  8'd5, 8'd0, 8'd7, 8'd0, 8'h01, 3'd3, 1'b1, 9'h084, 8'd5, 8'd0, 8'd7, 8'd0}, // R6 flush spill
        '{8'd7,  8'd2, 8'd3, 8'd7, 8'd0, 8'h00, 3'd4, 1'b0, 9'h000, 8'd3, 8'd2, 8'd7, 8'd0}, // R7 own
        '{8'd7,  8'd2, 8'd3, 8'd7, 8'd2, 8'h00, 3'd4, 1'b0, 9'h000, 8'd3, 8'd3, 8'd7, 8'd1}, // R7 foreign
        '{8'd8,  8'd3, 8'd1, 8'd4, 8'd0, 8'h00, 3'd5, 1'b0, 9'h000, 8'd2, 8'd2, 8'd5, 8'd0}, // R8 own
        '{8'd8,  8'd3, 8'd1, 8'd7, 8'd1, 8'h00, 3'd5, 1'b0, 9'h000, 8'd3, 8'd2, 8'd7, 8'd0}  // R8 capped
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // called at a falling edge; result visible at the next falling edge
    task automatic wr(input logic [2:0] sel, input logic [7:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic op(input logic [2:0] code);
        op_valid = 1'b1; op_code = code;
        @(negedge clk);
        op_valid = 1'b0; op_code = 3'd0;
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11", "cansave", int'(cansave_o), NWIN - 2);
        chk("R11", "canrestore", int'(canrestore_o), 0);
        chk("R11", "cleanwin", int'(cleanwin_o), NWIN - 1);
        chk("R11", "otherwin", int'(otherwin_o), 0);
        chk("R11", "wstate", int'(wstate_o), 0);
        chk("R11", "cwp", int'(cwp_o), NWIN - 1);
        chk("R11", "trap_valid", int'(trap_valid), 0);

        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = $sformatf("R%0d", VECS[i].rq);
            wr(3'd0, VECS[i].cs);
            wr(3'd1, VECS[i].cr);
            wr(3'd2, VECS[i].cw);
            wr(3'd3, VECS[i].ow);
            wr(3'd4, VECS[i].ws);
            op(VECS[i].op);
            chk(rq, $sformatf("v%0d trap_valid", i), int'(trap_valid), int'(VECS[i].trap));
            chk(rq, $sformatf("v%0d trap_type", i), int'(trap_type), int'(VECS[i].tt));
            chk(rq, $sformatf("v%0d cansave", i), int'(cansave_o), int'(VECS[i].ecs));
            chk(rq, $sformatf("v%0d canrestore", i), int'(canrestore_o), int'(VECS[i].ecr));
            chk(rq, $sformatf("v%0d cleanwin", i), int'(cleanwin_o), int'(VECS[i].ecw));
            chk(rq, $sformatf("v%0d otherwin", i), int'(otherwin_o), int'(VECS[i].eow));
            @(negedge clk);
            chk("R10", $sformatf("v%0d trap cleared", i), int'(trap_valid), 0);
            chk("R4", $sformatf("v%0d idle type", i), int'(trap_type), 0);
        end

        // R9 pointer writes reduced modulo NWIN
        wr(3'd5, 8'd11);
        chk("R9", "cwp after 11", int'(cwp_o), 3);
        wr(3'd5, 8'd8);
        chk("R9", "cwp after 8", int'(cwp_o), 0);
        wr(3'd5, 8'd255);
        chk("R9", "cwp after 255", int'(cwp_o), 7);

        // R5 pointer wraps on save, returns on restore
        wr(3'd0, 8'd3); wr(3'd1, 8'd0); wr(3'd2, 8'd7); wr(3'd3, 8'd0);
        op(3'd1);
        chk("R5", "cwp after save wrap", int'(cwp_o), 0);
        @(negedge clk);
        op(3'd2);
        chk("R5", "cwp after restore wrap", int'(cwp_o), 7);
        @(negedge clk);

        // R12 low-bit truncation of writes
        wr(3'd0, 8'h0D);
        chk("R12", "cansave trunc", int'(cansave_o), 5);
        wr(3'd4, 8'hFF);
        chk("R12", "wstate trunc", int'(wstate_o), 63);

        // R10 trap holds pointer; op during trap ignored
        wr(3'd0, 8'd0); wr(3'd1, 8'd2); wr(3'd2, 8'd7);
        op(3'd1);
        chk("R1", "trap on save", int'(trap_valid), 1);
        chk("R1", "cwp held", int'(cwp_o), 7);
        op(3'd2);
        chk("R10", "trap one cycle", int'(trap_valid), 0);
        chk("R10", "restore in trap ignored", int'(canrestore_o), 2);
        chk("R10", "cwp after ignored", int'(cwp_o), 7);

        // R10 op together with write: write applied, op dropped
        op_valid = 1'b1; op_code = 3'd2;
        wr(3'd4, 8'h15);
        op_valid = 1'b0; op_code = 3'd0;
        chk("R10", "wstate written", int'(wstate_o), 8'h15);
        chk("R10", "op with write ignored", int'(canrestore_o), 2);
        chk("R10", "no trap", int'(trap_valid), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule